// File: doc/BRIEF.md
# RTC Tamper Detection Unit

This block guards a bank of battery-backed backup registers against physical tampering. It watches a small set of tamper pins, two by default. Each pin passes through a two-flop synchronizer. Each pin is then checked either for an edge or for a level that must hold across several ticks of a slow sample clock. A detected event sets a per-pin flag and may request an interrupt. It may also raise a timestamp flag and capture the current time value. Unless erase is suppressed for the pin that fired, the event wipes the whole backup bank.

Software reaches the controls, flags, timestamp and backup words through a plain single-cycle register port. Writes take effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no data stream, so it has no valid/ready handshake and no back-pressure: every access completes in its own cycle.

The design has two resets. `sys_rst_n` clears the controls, flags and detectors. `bkp_rst_n` is the backup-domain reset and is the only reset that clears the backup words.

The word map is as follows. Word 0 is control: enable of input i at bit i, active-edge or active-level select at bit 8+i, erase suppress at bit 16+i, filter at bits 25:24, interrupt enable at bit 28, timestamp-on-tamper at bit 29, and software erase at bit 31, which is write-only and reads 0. Word 1 holds the flags: the flag of input i at bit i and the timestamp flag at bit 8. Word 2 is the captured time. Words 4 to 4+NUM_BKP-1 are the backup words. All other words read 0.

Top module: `rtc_tamper_unit`

## Requirements
- R1: After `sys_rst_n` and `bkp_rst_n` are applied, every register word reads 0, `tamp_irq` is 0 and every `pullup_en` bit is 0.
- R2: With filter 0 (edge mode), an enabled input whose edge bit is 0 fires on a rising pin edge; with edge bit 1 it fires on a falling edge. The input's flag reads 1 after the third rising clock edge that follows the pin change.
- R3: With filter f of 1, 2 or 3 (level mode), an enabled input fires once when its active level (edge bit 0: high, 1: low) is seen on 2, 4 or 8 consecutive `sample_tick` cycles. Any clock cycle with the inactive level restarts the count.
- R4: Writes to an input's edge and erase-suppress bits are ignored while that input is enabled. Writes to the filter field are ignored while any input is enabled. Interrupt enable, timestamp enable and the enables themselves are always writable.
- R5: `tamp_irq` is 1 exactly when at least one tamper flag is 1 and the interrupt enable bit is 1.
- R6: A tamper event clears every backup word to 0 in the same edge that sets the flag, unless the erase-suppress bit of the input that fired is 1.
- R7: Writing 1 to control bit 31 clears every backup word to 0, whether or not any input is enabled.
- R8: `sys_rst_n` leaves the backup words unchanged. `bkp_rst_n` clears them.
- R9: With timestamp-on-tamper set, a tamper event sets the timestamp flag and latches `time_now` into word 2. The tamper flag is set whatever that bit is.
- R10: Every `pullup_en` bit is 0 while the filter field is 0 and 1 while it is nonzero.
- R11: A tamper erase and a backup-word write in the same cycle leave the word at 0.
- R12: Flags are cleared by writing 1 to them in word 1. A new event in the same cycle as the clearing write leaves the flag set.
- R13: A disabled input never sets a flag, erases or raises an interrupt, whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| tamp_pin | input | NUM_TAMP | Tamper pins, asynchronous |
| sample_tick | input | 1 | One-cycle enable from the slow sample clock |
| time_now | input | TIME_W | Current time value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| tamp_irq | output | 1 | Tamper interrupt request |
| pullup_en | output | NUM_TAMP | Pad pull-up enable per pin |

## Verification
A wrong detector state shows up at the ports in one of three ways: a flag bit in word 1 appearing or missing, the backup words turning to zero, or `tamp_irq` moving. This becomes visible three clock edges after the pin change in edge mode, or on the qualifying `sample_tick` in level mode. A wrong control or lock state is visible in word 0 on the cycle after the write. It is also visible later, because the input then fires on the wrong edge or erases when it should not. The bench compares the read word, `tamp_irq` and `pullup_en` against its own model after every clock edge, so a divergence is reported in the cycle it first appears.

// File: rtl/rtc_tamper_pkg.sv
package rtc_tamper_pkg;
  localparam int FILT_W      = 2;
  localparam int CTRL_ADDR   = 0;
  localparam int FLAG_ADDR   = 1;
  localparam int TS_ADDR     = 2;
  localparam int BKP_BASE    = 4;
  localparam int EN_LSB      = 0;
  localparam int EDGE_LSB    = 8;
  localparam int NOER_LSB    = 16;
  localparam int FILT_LSB    = 24;
  localparam int IRQEN_BIT   = 28;
  localparam int TSEN_BIT    = 29;
  localparam int SWERASE_BIT = 31;
  localparam int TSF_BIT     = 8;

  typedef enum logic [1:0] {
    FILT_EDGE = 2'd0,
    FILT_L2   = 2'd1,
    FILT_L4   = 2'd2,
    FILT_L8   = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/rtc_tamper_detect.sv
module rtc_tamper_detect
  import rtc_tamper_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              enable,
  input  logic              edge_fall,
  input  logic [FILT_W-1:0] filter,
  input  logic              sample_tick,
  output logic              event_o
);
  logic [2:0]       sync_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] target;
  logic             level, prev, active, edge_hit, lvl_hit, lvl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin};
  end

  assign level    = sync_q[1];
  assign prev     = sync_q[2];
  assign active   = level ^ edge_fall;
  assign lvl_mode = (filter != FILT_EDGE);
  assign target   = CNT_W'(1) << filter;
  assign edge_hit = edge_fall ? (prev & ~level) : (~prev & level);
  assign lvl_hit  = active & sample_tick & (run_q == target - CNT_W'(1));
  assign event_o  = enable & (lvl_mode ? lvl_hit : edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            run_q <= '0;
    else if (!enable || !lvl_mode || !active) run_q <= '0;
    else if (sample_tick && run_q != target) run_q <= run_q + CNT_W'(1);
  end

  p_level_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && lvl_mode) |=> !event_o);
  p_level_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && lvl_mode) |-> (run_q != '0));
endmodule

// File: rtl/rtc_tamper_regs.sv
module rtc_tamper_regs
  import rtc_tamper_pkg::*;
#(
  parameter int NUM_TAMP = 2,
  parameter int DATA_W   = 32,
  parameter int TIME_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_TAMP-1:0] tamp_event,
  input  logic [TIME_W-1:0]   time_now,
  output logic [NUM_TAMP-1:0] enable,
  output logic [NUM_TAMP-1:0] edge_fall,
  output logic [FILT_W-1:0]   filter,
  output logic                irq,
  output logic                erase,
  output logic [DATA_W-1:0]   rdata
);
  logic [NUM_TAMP-1:0] en_q, edge_q, noer_q, tflag_q, clr_mask;
  logic [FILT_W-1:0]   filt_q;
  logic                irqen_q, tsen_q, tsf_q;
  logic [TIME_W-1:0]   ts_q;
  logic                ctrl_wr, flag_wr, ts_hit;

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign flag_wr  = wr_en && (addr == ADDR_W'(FLAG_ADDR));
  assign clr_mask = flag_wr ? wdata[NUM_TAMP-1:0] : '0;
  assign ts_hit   = tsen_q && (|tamp_event);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      edge_q  <= '0;
      noer_q  <= '0;
      filt_q  <= '0;
      irqen_q <= 1'b0;
      tsen_q  <= 1'b0;
    end else if (ctrl_wr) begin
      for (int i = 0; i < NUM_TAMP; i++) begin
        en_q[i] <= wdata[EN_LSB+i];
        if (!en_q[i]) begin
          edge_q[i] <= wdata[EDGE_LSB+i];
          noer_q[i] <= wdata[NOER_LSB+i];
        end
      end
      if (en_q == '0) filt_q <= wdata[FILT_LSB +: FILT_W];
      irqen_q <= wdata[IRQEN_BIT];
      tsen_q  <= wdata[TSEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag_q <= '0;
      tsf_q   <= 1'b0;
      ts_q    <= '0;
    end else begin
      tflag_q <= (tflag_q & ~clr_mask) | tamp_event;
      if (ts_hit) begin
        tsf_q <= 1'b1;
        ts_q  <= time_now;
      end else if (flag_wr && wdata[TSF_BIT]) begin
        tsf_q <= 1'b0;
      end
    end
  end

  assign enable    = en_q;
  assign edge_fall = edge_q;
  assign filter    = filt_q;
  assign irq       = irqen_q && (|tflag_q);
  assign erase     = (|(tamp_event & ~noer_q)) || (ctrl_wr && wdata[SWERASE_BIT]);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      for (int i = 0; i < NUM_TAMP; i++) begin
        rdata[EN_LSB+i]   = en_q[i];
        rdata[EDGE_LSB+i] = edge_q[i];
        rdata[NOER_LSB+i] = noer_q[i];
      end
      rdata[FILT_LSB +: FILT_W] = filt_q;
      rdata[IRQEN_BIT]          = irqen_q;
      rdata[TSEN_BIT]           = tsen_q;
    end else if (addr == ADDR_W'(FLAG_ADDR)) begin
      rdata[NUM_TAMP-1:0] = tflag_q;
      rdata[TSF_BIT]      = tsf_q;
    end else if (addr == ADDR_W'(TS_ADDR)) begin
      rdata[TIME_W-1:0] = ts_q;
    end
  end

  for (genvar g = 0; g < NUM_TAMP; g++) begin : g_chk
    p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[g] |=> ($stable(edge_q[g]) && $stable(noer_q[g])));
    p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tflag_q[g]) |-> $past(tamp_event[g]));
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tflag_q[g] && !(flag_wr && wdata[g])) |=> tflag_q[g]);
  end
  p_ts_on_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tsen_q && (|tamp_event)) |=> tsf_q);
endmodule

// File: rtl/rtc_tamper_bkp.sv
module rtc_tamper_bkp #(
  parameter int NUM_BKP = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              bkp_rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_q [NUM_BKP];

  for (genvar k = 0; k < NUM_BKP; k++) begin : g_word
    always_ff @(posedge clk or negedge bkp_rst_n) begin
      if (!bkp_rst_n)                              bank_q[k] <= '0;
      else if (erase)                              bank_q[k] <= '0;
      else if (wr_en && wr_idx == IDX_W'(k))       bank_q[k] <= wdata;
    end
    p_erase_clears_r6: assert property (@(posedge clk) disable iff (!bkp_rst_n)
      erase |=> (bank_q[k] == '0));
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!bkp_rst_n)
      (wr_en && !erase && wr_idx == IDX_W'(k)) |=> (bank_q[k] == $past(wdata)));
  end

  assign rdata = (int'(rd_idx) < NUM_BKP) ? bank_q[rd_idx] : '0;
endmodule

// File: rtl/rtc_tamper_unit.sv
module rtc_tamper_unit
  import rtc_tamper_pkg::*;
#(
  parameter int NUM_TAMP = 2,
  parameter int NUM_BKP  = 8,
  parameter int DATA_W   = 32,
  parameter int TIME_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                sys_rst_n,
  input  logic                bkp_rst_n,
  input  logic [NUM_TAMP-1:0] tamp_pin,
  input  logic                sample_tick,
  input  logic [TIME_W-1:0]   time_now,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                tamp_irq,
  output logic [NUM_TAMP-1:0] pullup_en
);
  localparam int IDX_W = (NUM_BKP > 1) ? $clog2(NUM_BKP) : 1;
  localparam int CNT_W = (1 << FILT_W);

  logic [NUM_TAMP-1:0] enable, edge_fall, tamp_event;
  logic [FILT_W-1:0]   filter;
  logic                erase, in_bkp, bkp_wr;
  logic [ADDR_W-1:0]   bkp_off;
  logic [IDX_W-1:0]    bkp_idx;
  logic [DATA_W-1:0]   ctl_rdata, bkp_rdata;

  for (genvar i = 0; i < NUM_TAMP; i++) begin : g_in
    rtc_tamper_detect #(.CNT_W(CNT_W)) u_det (
      .clk(clk), .rst_n(sys_rst_n), .pin(tamp_pin[i]), .enable(enable[i]),
      .edge_fall(edge_fall[i]), .filter(filter), .sample_tick(sample_tick),
      .event_o(tamp_event[i]));
  end

  rtc_tamper_regs #(.NUM_TAMP(NUM_TAMP), .DATA_W(DATA_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(sys_rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tamp_event(tamp_event), .time_now(time_now), .enable(enable), .edge_fall(edge_fall),
    .filter(filter), .irq(tamp_irq), .erase(erase), .rdata(ctl_rdata));

  assign bkp_off = reg_addr - ADDR_W'(BKP_BASE);
  assign in_bkp  = (int'(reg_addr) >= BKP_BASE) && (int'(reg_addr) < BKP_BASE + NUM_BKP);
  assign bkp_idx = bkp_off[IDX_W-1:0];
  assign bkp_wr  = reg_wr && in_bkp;

  rtc_tamper_bkp #(.NUM_BKP(NUM_BKP), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bkp (
    .clk(clk), .bkp_rst_n(bkp_rst_n), .erase(erase), .wr_en(bkp_wr), .wr_idx(bkp_idx),
    .wdata(reg_wdata), .rd_idx(bkp_idx), .rdata(bkp_rdata));

  assign reg_rdata = in_bkp ? bkp_rdata : ctl_rdata;
  assign pullup_en = {NUM_TAMP{filter != FILT_EDGE}};

  p_pullup_level_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR) && enable == '0) |=>
      (pullup_en[0] == ($past(reg_wdata[FILT_LSB +: FILT_W]) != '0)));
  p_disabled_quiet_r13: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (enable == '0 && !reg_wr) |=> $stable(tamp_irq));
endmodule

// File: tb/rtc_tamper_unit_test.sv
module rtc_tamper_unit_test;
  localparam int NT = 2;
  localparam int NB = 8;

  logic clk = 0;
  logic sys_rst_n = 0, bkp_rst_n = 0;
  logic [NT-1:0] tamp_pin = '0;
  logic sample_tick = 0;
  logic [31:0] time_now = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic tamp_irq;
  logic [NT-1:0] pullup_en;

  always #10 clk = ~clk;

  rtc_tamper_unit uut (
    .clk(clk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n), .tamp_pin(tamp_pin),
    .sample_tick(sample_tick), .time_now(time_now), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tamp_irq(tamp_irq), .pullup_en(pullup_en));

  int checks = 0, errors = 0, cyc = 0;
  string req = "R1";
  bit tick_on = 0;
  int tick_div = 0;
  int rr = 0;

  // behavioural model state
  bit m_s1[NT], m_s2[NT], m_s3[NT];
  int m_cnt[NT];
  bit m_en[NT], m_edge[NT], m_noer[NT], m_flag[NT];
  int m_filt;
  bit m_irqen, m_tsen, m_tsf;
  logic [31:0] m_ts;
  logic [31:0] m_bkp[NB];

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] v = 0;
    if (a == 0) begin
      for (int i = 0; i < NT; i++) begin
        v[i] = m_en[i]; v[8+i] = m_edge[i]; v[16+i] = m_noer[i];
      end
      v[25:24] = 2'(m_filt); v[28] = m_irqen; v[29] = m_tsen;
    end else if (a == 1) begin
      for (int i = 0; i < NT; i++) v[i] = m_flag[i];
      v[8] = m_tsf;
    end else if (a == 2) v = m_ts;
    else if (a >= 4 && a < 4 + NB) v = m_bkp[a-4];
    return v;
  endfunction

  always @(posedge clk) begin
    bit ev[NT];
    bit any_ev, erase;
    bit old_en[NT];
    bit anyen;
    erase = 0; any_ev = 0;
    for (int i = 0; i < NT; i++) ev[i] = 0;
    if (!sys_rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_cnt[i] = 0;
        m_en[i] = 0; m_edge[i] = 0; m_noer[i] = 0; m_flag[i] = 0;
      end
      m_filt = 0; m_irqen = 0; m_tsen = 0; m_tsf = 0; m_ts = 0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        bit act;
        int n;
        n = 1 << m_filt;
        act = m_s2[i] ^ m_edge[i];
        if (m_en[i]) begin
          if (m_filt == 0) ev[i] = m_edge[i] ? (m_s3[i] && !m_s2[i]) : (!m_s3[i] && m_s2[i]);
          else ev[i] = act && sample_tick && (m_cnt[i] == n - 1);
        end
        if (!m_en[i] || m_filt == 0 || !act) m_cnt[i] = 0;
        else if (sample_tick && m_cnt[i] < n) m_cnt[i]++;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = tamp_pin[i];
        if (ev[i]) begin any_ev = 1; if (!m_noer[i]) erase = 1; end
      end
      anyen = 0;
      for (int i = 0; i < NT; i++) begin old_en[i] = m_en[i]; anyen |= m_en[i]; end
      if (reg_wr && reg_addr == 0) begin
        for (int i = 0; i < NT; i++) begin
          m_en[i] = reg_wdata[i];
          if (!old_en[i]) begin m_edge[i] = reg_wdata[8+i]; m_noer[i] = reg_wdata[16+i]; end
        end
        if (!anyen) m_filt = int'(reg_wdata[25:24]);
        m_irqen = reg_wdata[28]; m_tsen = reg_wdata[29];
        if (reg_wdata[31]) erase = 1;
      end
      if (m_tsen_prev_ok(any_ev)) begin m_tsf = 1; m_ts = time_now; end
      else if (reg_wr && reg_addr == 1 && reg_wdata[8]) m_tsf = 0;
      for (int i = 0; i < NT; i++) begin
        if (reg_wr && reg_addr == 1 && reg_wdata[i]) m_flag[i] = 0;
        if (ev[i]) m_flag[i] = 1;
      end
    end
    if (!bkp_rst_n) begin
      for (int k = 0; k < NB; k++) m_bkp[k] = 0;
    end else if (erase) begin
      for (int k = 0; k < NB; k++) m_bkp[k] = 0;
    end else if (reg_wr && reg_addr >= 4 && int'(reg_addr) < 4 + NB) begin
      m_bkp[reg_addr-4] = reg_wdata;
    end
  end

  // timestamp enable is sampled before this edge's control write
  bit m_tsen_q;
  always @(posedge clk) m_tsen_q <= (sys_rst_n ? m_tsen : 1'b0);
  function automatic bit m_tsen_prev_ok(input bit ev_any);
    return ev_any && m_tsen_q;
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #5;
    chk(req, "rdata", reg_rdata, m_read(int'(reg_addr)));
    chk((req == "R1") ? "R1" : "R5", "irq", 32'(tamp_irq),
        32'((m_irqen && (m_flag[0] || m_flag[1])) ? 1 : 0));
    chk((req == "R1") ? "R1" : "R10", "pullup", 32'(pullup_en), (m_filt != 0) ? 32'h3 : 32'h0);
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    time_now <= time_now + 32'd7;
    tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
    sample_tick <= tick_on && (tick_div == 0);
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reg_addr = 4'(rr);
      rr = (rr == 11) ? 0 : rr + 1;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pin(input int i, input bit v);
    @(negedge clk); tamp_pin[i] = v;
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] en, input logic [1:0] edg,
      input logic [1:0] noer, input logic [1:0] filt, input bit ie, input bit te);
    return {2'b0, te, ie, 2'b0, filt, 6'b0, noer, 6'b0, edg, 6'b0, en};
  endfunction

  task automatic fill(input logic [31:0] base);
    for (int k = 0; k < NB; k++) wr(4 + k, base + 32'(k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    sys_rst_n = 1; bkp_rst_n = 1;
    req = "R1"; idle(14);

    req = "R2"; fill(32'hA000_0000);
    wr(0, ctl(2'b11, 2'b10, 2'b11, 0, 0, 0));
    idle(4); pin(0, 1); idle(8); pin(1, 1); idle(8); pin(1, 0); idle(8);
    req = "R5"; wr(0, ctl(2'b11, 2'b10, 2'b11, 0, 1, 0)); idle(6);
    req = "R12"; wr(1, 32'h1); idle(4); wr(1, 32'h2); idle(6);

    req = "R4"; wr(0, ctl(2'b11, 2'b01, 2'b00, 2, 1, 0)); idle(6);
    pin(0, 0); idle(8); pin(0, 1); idle(8); wr(1, 32'h3); idle(4);

    req = "R13"; wr(0, ctl(2'b01, 2'b00, 2'b11, 0, 1, 0));
    pin(1, 1); idle(6); pin(1, 0); idle(6); pin(1, 1); idle(6);

    req = "R10"; wr(0, 32'h0); wr(0, ctl(2'b00, 2'b00, 2'b11, 1, 0, 0)); idle(12);
    req = "R3"; tick_on = 1; pin(0, 0);
    wr(0, ctl(2'b01, 2'b00, 2'b11, 1, 1, 0)); idle(6);
    pin(0, 1); idle(3); pin(0, 0); idle(6);
    pin(0, 1); idle(30); pin(0, 0); idle(6); wr(1, 32'h1);
    wr(0, 32'h0); wr(0, ctl(2'b11, 2'b10, 2'b11, 3, 1, 0));
    pin(1, 1); idle(10); pin(1, 0); idle(12); pin(1, 1); idle(6); pin(1, 0); idle(40);
    pin(1, 1); idle(6); tick_on = 0;

    req = "R9"; wr(0, 32'h0); wr(1, 32'h103);
    wr(0, ctl(2'b01, 2'b00, 2'b11, 0, 1, 1)); pin(0, 0); idle(6); pin(0, 1); idle(8);
    req = "R9"; wr(0, ctl(2'b01, 2'b00, 2'b11, 0, 1, 0)); wr(1, 32'h1);
    pin(0, 0); idle(4); pin(0, 1); idle(8);

    req = "R6"; wr(0, 32'h0); fill(32'hB000_0000);
    wr(0, ctl(2'b01, 2'b00, 2'b00, 0, 0, 0)); pin(0, 0); idle(6); pin(0, 1); idle(14);

    req = "R7"; wr(0, 32'h0); fill(32'hC000_0000); idle(4);
    wr(0, 32'h8000_0000); idle(14);

    req = "R11"; fill(32'hD000_0000);
    wr(0, ctl(2'b01, 2'b00, 2'b00, 0, 0, 0)); pin(0, 0); idle(6);
    @(negedge clk); tamp_pin[0] = 1; reg_wr = 1;
    for (int c = 0; c < 6; c++) begin
      reg_addr = 4; reg_wdata = 32'hE000_0000 + 32'(c); @(negedge clk);
    end
    reg_wr = 0; idle(14);

    req = "R12"; wr(0, ctl(2'b01, 2'b00, 2'b11, 0, 1, 0)); pin(0, 0); idle(6);
    @(negedge clk); tamp_pin[0] = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h1;
    repeat (5) @(negedge clk);
    reg_wr = 0; idle(8);

    req = "R8"; wr(0, 32'h0); fill(32'hF000_0000);
    @(negedge clk); sys_rst_n = 0; idle(3); sys_rst_n = 1; idle(14);
    @(negedge clk); bkp_rst_n = 0; idle(3); bkp_rst_n = 1; idle(14);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule